// File: doc/BRIEF.md
# Machine Trap Vector Dispatch Unit

This block sits beside a simple in-order core and decides where instruction fetch goes next when the machine-level trap state asks for a change of flow. It holds a software-writable trap-vector register. The lowest bit selects the dispatch style, and the upper bits give a word-aligned handler base. The block also holds the saved trap PC, the cause record, the interrupt enable mask, and the one software-settable pending bit.

A synchronous exception from the core, or a level interrupt line that is both enabled and pending, raises `trap_taken`. In the same cycle, `redirect_pc` carries the handler address. In direct style, every trap goes to the base. In vectored style, exceptions still go to the base, but interrupts go to base + 4 × cause. The user-level software interrupt bit is tied to zero, so interrupt cause 0 never lands on the exception entry.

A return request restores the fetch address from the saved trap PC and re-opens interrupt acceptance. Directly after reset, the block requests a fetch from the boot address.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset release, the first cycle shows `redirect_valid`=1, `redirect_pc`=0x1000 and `trap_taken`=0. The vector, cause, saved PC and enable registers read as 0. In later idle cycles, `redirect_valid` is 0.
- R2: The vector register (select 0) is written through the CSR port at run time and is fully writable. Bit 0 is the style: 0 is direct, 1 is vectored. Bits 31:2 are the base. Bit 1 always reads 0.
- R3: In direct style, every trap (exception or interrupt) gives `redirect_pc` = base.
- R4: In vectored style, an exception gives base, and an interrupt gives base + 4×cause. The causes and their offsets are: supervisor software 1 (+4), machine software 3 (+12), timer 7 (+28), external 11 (+44).
- R5: At the clock edge ending a trap cycle, the saved PC (select 2) takes `cur_pc`. The cause register (select 1) takes the interrupt flag in bit 31 and the code in its low bits.
- R6: An interrupt is taken only when `glb_irq_en`=1, acceptance is open, and (pending AND enable) is non-zero. The priority order is 11, then 3, then 1, then 7.
- R7: An exception in the same cycle as a pending interrupt wins. It records cause = exception code with flag 0.
- R8: Bit 0 of the enable register (select 3) and of the pending register (select 4) always reads 0, and writes to it are ignored. Enable bits 1, 3, 7 and 11 are writable.
- R9: Pending bit 1 is set or cleared by a CSR write. When it is enabled, it raises cause 1.
- R10: Pending bits 3, 7 and 11 mirror `irq_msw_i`, `irq_tmr_i` and `irq_ext_i`. CSR writes do not change them.
- R11: Taking a trap closes interrupt acceptance. A `mret_req` with no trap in the same cycle gives `redirect_valid`=1 with `redirect_pc` = saved PC, and re-opens acceptance.
- R12: `trap_taken`, `redirect_valid` and `redirect_pc` are combinational on the current inputs and state. The target appears in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction in the trap-decision stage |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code |
| irq_msw_i | input | 1 | Machine software interrupt line (level) |
| irq_tmr_i | input | 1 | Machine timer interrupt line (level) |
| irq_ext_i | input | 1 | Machine external interrupt line (level) |
| glb_irq_en | input | 1 | Global interrupt enable |
| mret_req | input | 1 | Return-from-trap request |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 3 | Register select: 0 vector, 1 cause, 2 saved PC, 3 enable, 4 pending |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_sel` |
| trap_taken | output | 1 | A trap is taken this cycle |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | Next fetch address |

## Verification
The assertions take for granted that `exc_req`, `mret_req` and the CSR controls are stable around the clock edge. They also assume a return is only meaningful when no trap is taken in the same cycle; the block resolves that overlap by letting the trap win, and the properties are written with that precedence. The directed stimulus keeps CSR writes to cause and saved PC out of trap cycles. It drops the level interrupt lines before it issues each return, so every handler entry can be checked against a hand-computed address. A random phase then mixes all inputs freely, including overlaps, and relies on the cycle model's precedence rules.

// File: rtl/tvu_pkg.sv
// Shared constants for the trap vector dispatch unit.
// Assumes the standard machine interrupt bit positions for cause codes.
package tvu_pkg;
    typedef enum logic [2:0] {
        SEL_TVEC  = 3'd0,
        SEL_CAUSE = 3'd1,
        SEL_EPC   = 3'd2,
        SEL_IE    = 3'd3,
        SEL_IP    = 3'd4
    } csr_sel_e;

    localparam int unsigned CODE_SSW = 1;
    localparam int unsigned CODE_MSW = 3;
    localparam int unsigned CODE_TMR = 7;
    localparam int unsigned CODE_EXT = 11;
endpackage

// File: rtl/tvu_irq_pick.sv
// Fixed-priority interrupt selector.
// Takes the enabled-and-pending vector; reports whether any is set and the
// winning cause code. Assumes only the four machine-level bits can be set.
module tvu_irq_pick #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic [XLEN-1:0]   pend,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    import tvu_pkg::*;

    // Purpose: pick the highest-priority source (ext > msw > ssw > timer).
    always_comb begin
        hit  = |pend;
        code = '0;
        if (pend[CODE_EXT])      code = CODE_W'(CODE_EXT);
        else if (pend[CODE_MSW]) code = CODE_W'(CODE_MSW);
        else if (pend[CODE_SSW]) code = CODE_W'(CODE_SSW);
        else if (pend[CODE_TMR]) code = CODE_W'(CODE_TMR);
    end
endmodule

// File: rtl/tvu_target.sv
// Handler address calculator.
// Direct style or exception: base. Vectored style interrupt: base + 4*code.
// Assumes the vector register keeps the style flag in bit 0.
module tvu_target #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic [XLEN-1:0]   tvec,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Purpose: form the aligned base and the optional per-cause offset.
    always_comb begin
        base   = {tvec[XLEN-1:2], 2'b00};
        offset = (is_irq && tvec[0]) ? (XLEN'(code) << 2) : '0;
        target = base + offset;
    end
endmodule

// File: rtl/trap_vector_unit.sv
// Machine trap vector dispatch unit (top).
// Holds the vector, cause, saved-PC, enable and software-pending state,
// decides trap entry and return, and presents the fetch redirect.
// Assumes one trap-decision point per cycle and a synchronous active-low reset.
module trap_vector_unit #(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_msw_i,
    input  logic              irq_tmr_i,
    input  logic              irq_ext_i,
    input  logic              glb_irq_en,
    input  logic              mret_req,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              trap_taken,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    import tvu_pkg::*;

    localparam logic [XLEN-1:0] IE_MASK =
        (XLEN'(1) << CODE_SSW) | (XLEN'(1) << CODE_MSW) |
        (XLEN'(1) << CODE_TMR) | (XLEN'(1) << CODE_EXT);

    logic [XLEN-1:0]   tvec_q;
    logic [XLEN-1:0]   cause_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   ie_q;
    logic              ssip_q;
    logic              inten_q;
    logic              boot_q;

    logic [XLEN-1:0]   ip_rd;
    logic              irq_hit;
    logic [CODE_W-1:0] irq_code;
    logic              irq_fire;
    logic              is_irq;
    logic [CODE_W-1:0] trap_code;
    logic [XLEN-1:0]   target;
    logic [XLEN-1:0]   cause_d;
    logic              wr_tvec, wr_cause, wr_epc, wr_ie, wr_ip;

    // Purpose: assemble the pending view from the lines and the soft bit.
    always_comb begin
        ip_rd           = '0;
        ip_rd[CODE_SSW] = ssip_q;
        ip_rd[CODE_MSW] = irq_msw_i;
        ip_rd[CODE_TMR] = irq_tmr_i;
        ip_rd[CODE_EXT] = irq_ext_i;
    end

    tvu_irq_pick #(.XLEN(XLEN), .CODE_W(CODE_W)) pick_i (
        .pend (ip_rd & ie_q),
        .hit  (irq_hit),
        .code (irq_code)
    );

    // Purpose: trap decision, exception over interrupt.
    always_comb begin
        irq_fire   = glb_irq_en && inten_q && irq_hit;
        trap_taken = exc_req || irq_fire;
        is_irq     = !exc_req && irq_fire;
        trap_code  = exc_req ? exc_code : irq_code;
        cause_d             = '0;
        cause_d[XLEN-1]     = is_irq;
        cause_d[CODE_W-1:0] = trap_code;
    end

    tvu_target #(.XLEN(XLEN), .CODE_W(CODE_W)) tgt_i (
        .tvec   (tvec_q),
        .is_irq (is_irq),
        .code   (trap_code),
        .target (target)
    );

    // Purpose: redirect selection, trap over return over boot.
    always_comb begin
        redirect_valid = boot_q || trap_taken || mret_req;
        if (trap_taken)    redirect_pc = target;
        else if (mret_req) redirect_pc = epc_q;
        else               redirect_pc = RESET_VEC;
    end

    // Purpose: decode CSR write strobes.
    always_comb begin
        wr_tvec  = csr_we && (csr_sel == SEL_TVEC);
        wr_cause = csr_we && (csr_sel == SEL_CAUSE);
        wr_epc   = csr_we && (csr_sel == SEL_EPC);
        wr_ie    = csr_we && (csr_sel == SEL_IE);
        wr_ip    = csr_we && (csr_sel == SEL_IP);
    end

    // Purpose: CSR read multiplexer.
    always_comb begin
        case (csr_sel)
            SEL_TVEC:  csr_rdata = tvec_q;
            SEL_CAUSE: csr_rdata = cause_q;
            SEL_EPC:   csr_rdata = epc_q;
            SEL_IE:    csr_rdata = ie_q;
            SEL_IP:    csr_rdata = ip_rd;
            default:   csr_rdata = '0;
        endcase
    end

    // Purpose: vector register, bit 1 forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       tvec_q <= '0;
        else if (wr_tvec) tvec_q <= {csr_wdata[XLEN-1:2], 1'b0, csr_wdata[0]};
    end

    // Purpose: cause and saved PC, trap entry overrides CSR writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (trap_taken) begin
            cause_q <= cause_d;
            epc_q   <= cur_pc;
        end else begin
            if (wr_cause) cause_q <= csr_wdata;
            if (wr_epc)   epc_q   <= csr_wdata;
        end
    end

    // Purpose: enable mask and the supervisor software pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= '0;
            ssip_q <= 1'b0;
        end else begin
            if (wr_ie) ie_q   <= csr_wdata & IE_MASK;
            if (wr_ip) ssip_q <= csr_wdata[CODE_SSW];
        end
    end

    // Purpose: acceptance gate and boot-fetch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inten_q <= 1'b1;
            boot_q  <= 1'b1;
        end else begin
            boot_q <= 1'b0;
            if (trap_taken)    inten_q <= 1'b0;
            else if (mret_req) inten_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tvu_checker.sv
// Assertion checker for trap_vector_unit, attached by bind.
// Assumes the top's internal state names tvec_q, epc_q, cause_q, ie_q,
// ip_rd, inten_q and boot_q.
module tvu_checker #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic            exc_req,
    input logic            mret_req,
    input logic            trap_taken,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] tvec_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] cause_q,
    input logic [XLEN-1:0] ie_q,
    input logic [XLEN-1:0] ip_rd,
    input logic            inten_q,
    input logic            boot_q
);
    logic [XLEN-1:0] base;
    assign base = {tvec_q[XLEN-1:2], 2'b00};

    assert_boot_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q && !trap_taken && !mret_req) |-> redirect_pc == RESET_VEC);

    assert_direct_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !tvec_q[0]) |-> redirect_pc == base);

    assert_exc_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && exc_req) |-> redirect_pc == base);

    assert_epc_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> epc_q == $past(cur_pc));

    assert_cause_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> cause_q[XLEN-1] == !$past(exc_req));

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && !exc_req) |-> inten_q);

    assert_user_bit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q[0] && !ip_rd[0]);

    assert_close_on_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !inten_q);

    assert_ret_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_taken) |-> redirect_pc == epc_q);
endmodule

bind trap_vector_unit tvu_checker #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_pc      (cur_pc),
    .exc_req     (exc_req),
    .mret_req    (mret_req),
    .trap_taken  (trap_taken),
    .redirect_pc (redirect_pc),
    .tvec_q      (tvec_q),
    .epc_q       (epc_q),
    .cause_q     (cause_q),
    .ie_q        (ie_q),
    .ip_rd       (ip_rd),
    .inten_q     (inten_q),
    .boot_q      (boot_q)
);

// File: tb/trap_vector_unit_tb_top.sv
// Bench: directed scenarios with hand-computed values, plus a behavioural
// cycle model compared on every falling edge.
module trap_vector_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        irq_msw_i = 1'b0, irq_tmr_i = 1'b0, irq_ext_i = 1'b0;
    logic        glb_irq_en = 1'b0;
    logic        mret_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        trap_taken, redirect_valid;
    logic [31:0] redirect_pc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trap_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_req(exc_req),
        .exc_code(exc_code), .irq_msw_i(irq_msw_i), .irq_tmr_i(irq_tmr_i),
        .irq_ext_i(irq_ext_i), .glb_irq_en(glb_irq_en), .mret_req(mret_req),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .trap_taken(trap_taken),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    // reference model state
    logic [31:0] m_tvec = '0, m_cause = '0, m_epc = '0, m_ie = '0;
    logic        m_ssip = 1'b0, m_open = 1'b1, m_boot = 1'b1;

    function automatic logic [31:0] m_ip();
        logic [31:0] v = '0;
        v[1] = m_ssip; v[3] = irq_msw_i; v[7] = irq_tmr_i; v[11] = irq_ext_i;
        return v;
    endfunction

    function automatic int m_irq_code();
        logic [31:0] p = m_ip() & m_ie;
        if (p[11]) return 11;
        if (p[3])  return 3;
        if (p[1])  return 1;
        if (p[7])  return 7;
        return -1;
    endfunction

    function automatic bit m_irq();
        return glb_irq_en && m_open && (m_irq_code() >= 0);
    endfunction

    function automatic bit m_trap();
        return exc_req || m_irq();
    endfunction

    function automatic logic [31:0] m_target();
        logic [31:0] base = m_tvec & 32'hFFFF_FFFC;
        if (!exc_req && m_tvec[0]) return base + 32'(4 * m_irq_code());
        return base;
    endfunction

    function automatic logic [31:0] m_rdata();
        case (csr_sel)
            3'd0: return m_tvec;
            3'd1: return m_cause;
            3'd2: return m_epc;
            3'd3: return m_ie;
            3'd4: return m_ip();
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tvec <= '0; m_cause <= '0; m_epc <= '0; m_ie <= '0;
            m_ssip <= 1'b0; m_open <= 1'b1; m_boot <= 1'b1;
        end else begin
            m_boot <= 1'b0;
            if (csr_we && csr_sel == 3'd0) m_tvec <= csr_wdata & 32'hFFFF_FFFD;
            if (csr_we && csr_sel == 3'd3) m_ie <= csr_wdata & 32'h0000_088A;
            if (csr_we && csr_sel == 3'd4) m_ssip <= csr_wdata[1];
            if (m_trap()) begin
                m_epc   <= cur_pc;
                m_cause <= exc_req ? {27'h0, exc_code} : (32'h8000_0000 | 32'(m_irq_code()));
                m_open  <= 1'b0;
            end else begin
                if (csr_we && csr_sel == 3'd1) m_cause <= csr_wdata;
                if (csr_we && csr_sel == 3'd2) m_epc <= csr_wdata;
                if (mret_req) m_open <= 1'b1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic v;
            v = m_boot || m_trap() || mret_req;
            check("R12 trap_taken", 32'(trap_taken), 32'(m_trap()));
            check("R12 redirect_valid", 32'(redirect_valid), 32'(v));
            if (v) check("R12 redirect_pc", redirect_pc,
                         m_trap() ? m_target() : (mret_req ? m_epc : 32'h1000));
            check("R2 csr_rdata", csr_rdata, m_rdata());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
        csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1; csr_sel = 3'd0; #2;
        check("R1 boot valid", 32'(redirect_valid), 32'd1);
        check("R1 boot pc", redirect_pc, 32'h1000);
        check("R1 no trap", 32'(trap_taken), 32'd0);
        check("R1 tvec reset", csr_rdata, 32'h0);
        step(); csr_wr(3'd0, 32'h0000_2000); #2;
        check("R1 idle valid", 32'(redirect_valid), 32'd0);
        step(); csr_we = 1'b0; exc_req = 1'b1; exc_code = 5'd2; cur_pc = 32'h400; #2;
        check("R2 tvec readback", csr_rdata, 32'h2000);
        check("R3 exc direct", redirect_pc, 32'h2000);
        check("R12 strobe", 32'(trap_taken), 32'd1);
        step(); exc_req = 1'b0; csr_sel = 3'd1; #2;
        check("R5 exc cause", csr_rdata, 32'h2);
        step(); csr_sel = 3'd2; mret_req = 1'b1; #2;
        check("R5 epc", csr_rdata, 32'h400);
        check("R11 return pc", redirect_pc, 32'h400);
        step(); mret_req = 1'b0; csr_wr(3'd3, 32'hFFFF_FFFF);
        step(); csr_wr(3'd4, 32'hFFFF_FFFF);
        step(); csr_we = 1'b0; csr_sel = 3'd3; #2;
        check("R8 ie mask", csr_rdata, 32'h88A);
        check("R6 gated by glb", 32'(trap_taken), 32'd0);
        step(); csr_sel = 3'd4; #2;
        check("R8 R9 R10 ip view", csr_rdata, 32'h2);
        step(); glb_irq_en = 1'b1; cur_pc = 32'h500; #2;
        check("R3 irq direct", redirect_pc, 32'h2000);
        check("R9 ssw fires", 32'(trap_taken), 32'd1);
        step(); csr_sel = 3'd1; #2;
        check("R5 irq cause", csr_rdata, 32'h8000_0001);
        check("R11 closed after trap", 32'(trap_taken), 32'd0);
        step(); csr_wr(3'd4, 32'h0);
        step(); csr_wr(3'd0, 32'h0000_2003);
        step(); csr_we = 1'b0; csr_sel = 3'd0; mret_req = 1'b1; #2;
        check("R2 bit1 reads zero", csr_rdata, 32'h2001);
        check("R11 return pc2", redirect_pc, 32'h500);
        step(); mret_req = 1'b0; irq_tmr_i = 1'b1; cur_pc = 32'h600; #2;
        check("R4 timer +28", redirect_pc, 32'h201C);
        step(); irq_tmr_i = 1'b0; csr_sel = 3'd1; #2;
        check("R5 timer cause", csr_rdata, 32'h8000_0007);
        step(); mret_req = 1'b1;
        step(); mret_req = 1'b0; irq_ext_i = 1'b1; irq_tmr_i = 1'b1; irq_msw_i = 1'b1; #2;
        check("R6 ext first", redirect_pc, 32'h202C);
        step(); irq_ext_i = 1'b0; irq_tmr_i = 1'b0; irq_msw_i = 1'b0; #2;
        check("R6 ext cause", csr_rdata, 32'h8000_000B);
        step(); mret_req = 1'b1;
        step(); mret_req = 1'b0; irq_msw_i = 1'b1; irq_tmr_i = 1'b1; #2;
        check("R6 msw before timer", redirect_pc, 32'h200C);
        step(); irq_msw_i = 1'b0; irq_tmr_i = 1'b0; mret_req = 1'b1;
        step(); mret_req = 1'b0; exc_req = 1'b1; exc_code = 5'd5; irq_ext_i = 1'b1; cur_pc = 32'h700; #2;
        check("R7 exc wins", redirect_pc, 32'h2000);
        step(); exc_req = 1'b0; irq_ext_i = 1'b0; #2;
        check("R7 exc cause", csr_rdata, 32'h5);
        step(); mret_req = 1'b1;
        step(); mret_req = 1'b0; csr_wr(3'd4, 32'h2);
        step(); csr_we = 1'b0; #2;
        check("R4 R9 ssw +4", redirect_pc, 32'h2004);
        step(); csr_wr(3'd4, 32'h0); mret_req = 1'b1;
        step(); csr_we = 1'b0; mret_req = 1'b0; glb_irq_en = 1'b0; irq_ext_i = 1'b1; csr_sel = 3'd4; #2;
        check("R10 ext mirrored", csr_rdata, 32'h800);
        check("R6 off with glb low", 32'(trap_taken), 32'd0);
        step(); csr_wr(3'd4, 32'h889);
        step(); csr_we = 1'b0; irq_ext_i = 1'b0; #2;
        check("R10 R8 writes ignored", csr_rdata, 32'h0);
        // random phase, compared by the cycle model
        for (int i = 0; i < 400; i++) begin
            step();
            exc_req    = ($urandom_range(0, 7) == 0);
            exc_code   = 5'($urandom_range(0, 15));
            irq_msw_i  = ($urandom_range(0, 3) == 0);
            irq_tmr_i  = ($urandom_range(0, 3) == 0);
            irq_ext_i  = ($urandom_range(0, 5) == 0);
            glb_irq_en = ($urandom_range(0, 3) != 0);
            mret_req   = ($urandom_range(0, 4) == 0);
            cur_pc     = $urandom() & 32'hFFFF_FFFC;
            csr_we     = ($urandom_range(0, 4) == 0);
            csr_sel    = 3'($urandom_range(0, 5));
            csr_wdata  = $urandom();
        end
        step();
        exc_req = 1'b0; mret_req = 1'b0; csr_we = 1'b0;
        step(); step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule